// File: doc/BRIEF.md
# Privilege-Level Event Count Filter

This block decides, once per clock, whether an event counter is allowed to count. It looks at the processor's current privilege level (0 to 3), its security state (secure, non-secure or realm), whether the vector unit is in streaming mode, and whether the processor is in a transactional state. A set of filter control bits then removes chosen combinations of these from counting. The block produces a single registered `count_allow` flag that the counter uses as its enable.

Each privilege level has a primary control bit. Level 1 and level 0 have a primary "exclude" bit, and level 2 has a primary "keep" bit, so a 0 there excludes level 2. Secondary per-state bits refine the primary bits. For levels 0, 1 and 3, a secondary bit excludes its combination when it differs from the primary bit. For level 2, a secondary bit excludes its combination when it equals the primary bit. A vector-mode selector and a non-transactional exclude bit add two more terms that do not depend on the level. The final decision is the AND of every term that applies to the current level and state. A term that does not apply counts as "allow".

Parameters state whether secure level 2, the realm state and level 3 exist. When a feature is absent, its control bits are forced to zero before they are used.

Top module: `plp_event_filter`

## Requirements
- R1: While `rst_n` is low, `count_allow` is 0. It stays 0 until the first rising clock edge after reset is released.
- R2: `count_allow` is registered. The value seen after rising edge k is the filter decision for the inputs sampled at edge k. When no term blocks, it is 1.
- R3: At level 1 (`cur_level`=1), `excl_l1`=1 blocks counting in every security state.
- R4: At level 0 (`cur_level`=0), `excl_l0`=1 blocks counting in every security state.
- R5: In the non-secure state (`sec_state`=01), counting is blocked at level 1 when `ns_l1_sel` differs from `excl_l1`. It is blocked at level 0 when `ns_l0_sel` differs from `excl_l0`.
- R6: In the realm state (`sec_state`=10), counting is blocked at level 1 when `rl_l1_sel` differs from `excl_l1`. It is blocked at level 0 when `rl_l0_sel` differs from `excl_l0`.
- R7: At level 2, `keep_l2`=0 blocks counting. In the secure state (`sec_state`=00, and also code 11, which is treated as secure), counting is blocked when `sec_l2_sel` equals `keep_l2`. In the realm state, counting is blocked when `rl_l2_sel` equals `keep_l2`.
- R8: At level 3, counting is blocked when `l3_sel` differs from `excl_l1`. `excl_l0` has no effect at level 3.
- R9: `vec_filter`=01 blocks counting while `vec_streaming`=1. `vec_filter`=10 blocks counting while `vec_streaming`=0. Codes 00 and 11 never block.
- R10: `excl_nontxn`=1 blocks counting when `evt_attrib`=1 and `in_txn`=0. It has no effect on unattributable events or inside a transaction.
- R11: Secondary bits belonging to another level or another security state have no effect. For example, the non-secure and realm bits do nothing in the secure state, and the level-1 and level-0 bits do nothing at level 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_level | input | 2 | Current privilege level, 0 to 3 |
| sec_state | input | 2 | 00 secure, 01 non-secure, 10 realm, 11 treated as secure |
| vec_streaming | input | 1 | 1 while the vector unit is in streaming mode |
| in_txn | input | 1 | 1 while in a transactional state |
| evt_attrib | input | 1 | 1 when the event is attributable to this processor |
| excl_l1 | input | 1 | Primary exclude for level 1, and reference for level 3 |
| excl_l0 | input | 1 | Primary exclude for level 0 |
| ns_l1_sel | input | 1 | Non-secure level-1 secondary bit |
| ns_l0_sel | input | 1 | Non-secure level-0 secondary bit |
| keep_l2 | input | 1 | Primary level-2 bit; 0 excludes level 2 |
| l3_sel | input | 1 | Level-3 secondary bit |
| sec_l2_sel | input | 1 | Secure level-2 secondary bit |
| rl_l1_sel | input | 1 | Realm level-1 secondary bit |
| rl_l0_sel | input | 1 | Realm level-0 secondary bit |
| rl_l2_sel | input | 1 | Realm level-2 secondary bit |
| excl_nontxn | input | 1 | Exclude attributable events outside transactions |
| vec_filter | input | 2 | Vector-mode filter selector |
| count_allow | output | 1 | Registered counter enable |

## Verification
Directed patterns walk each privilege level through each security state. At every level and state, the primary bit and the matching secondary bit are flipped on their own and then together. This separates the "differs" rule used at levels 0, 1 and 3 from the "equals" rule used at level 2, and it shows which state each secondary bit belongs to. The vector selector is tried with all four codes in both modes, which tells the reserved code apart from the two blocking codes. The non-transactional bit is crossed with the attributable and transactional flags. A long stretch of random inputs is then compared every cycle against a behavioural reference. That stretch catches cases where terms leak between levels or states, and cases where the decision appears on the wrong cycle.

// File: rtl/plp_pkg.sv
package plp_pkg;

   localparam int unsigned LVL_W   = 2;
   localparam int unsigned SEC_W   = 2;
   localparam int unsigned VSEL_W  = 2;
   localparam int unsigned N_LVL   = 1 << LVL_W;

   typedef enum logic [SEC_W-1:0] {
      SEC_SECURE = 2'b00,
      SEC_NONSEC = 2'b01,
      SEC_REALM  = 2'b10,
      SEC_RSVD   = 2'b11
   } plp_sec_e;

   typedef enum logic [VSEL_W-1:0] {
      VSEL_ANY      = 2'b00,
      VSEL_NO_STRM  = 2'b01,
      VSEL_NO_NSTRM = 2'b10,
      VSEL_RSVD     = 2'b11
   } plp_vsel_e;

   typedef struct packed {
      logic excl_l1;
      logic excl_l0;
      logic ns_l1;
      logic ns_l0;
      logic keep_l2;
      logic l3_sel;
      logic sec_l2;
      logic rl_l1;
      logic rl_l0;
      logic rl_l2;
   } plp_lvl_ctrl_t;

endpackage

// File: rtl/plp_ctrl_mask.sv
module plp_ctrl_mask
   import plp_pkg::*;
#(
   parameter int unsigned HAS_SEC_L2 = 1,
   parameter int unsigned HAS_REALM  = 1,
   parameter int unsigned HAS_L3     = 1
) (
   input  plp_lvl_ctrl_t raw_ctrl,
   output plp_lvl_ctrl_t eff_ctrl
);

   logic sec_l2_m;
   logic rl_l1_m;
   logic rl_l0_m;
   logic rl_l2_m;
   logic l3_m;

   generate
      if (HAS_SEC_L2 != 0) begin : g_sec_l2
         assign sec_l2_m = raw_ctrl.sec_l2;
      end else begin : g_no_sec_l2
         assign sec_l2_m = 1'b0;
      end

      if (HAS_REALM != 0) begin : g_realm
         assign rl_l1_m = raw_ctrl.rl_l1;
         assign rl_l0_m = raw_ctrl.rl_l0;
         assign rl_l2_m = raw_ctrl.rl_l2;
      end else begin : g_no_realm
         assign rl_l1_m = 1'b0;
         assign rl_l0_m = 1'b0;
         assign rl_l2_m = 1'b0;
      end

      if (HAS_L3 != 0) begin : g_l3
         assign l3_m = raw_ctrl.l3_sel;
      end else begin : g_no_l3
         assign l3_m = 1'b0;
      end
   endgenerate

   always_comb begin
      eff_ctrl         = raw_ctrl;
      eff_ctrl.sec_l2  = sec_l2_m;
      eff_ctrl.rl_l1   = rl_l1_m;
      eff_ctrl.rl_l0   = rl_l0_m;
      eff_ctrl.rl_l2   = rl_l2_m;
      eff_ctrl.l3_sel  = l3_m;
   end

endmodule

// File: rtl/plp_level_term.sv
module plp_level_term
   import plp_pkg::*;
(
   input  logic [LVL_W-1:0] cur_level,
   input  logic [SEC_W-1:0] sec_state,
   input  plp_lvl_ctrl_t    ctrl,
   output logic             lvl_allow
);

   logic is_ns;
   logic is_rl;
   logic is_sec;
   logic [N_LVL-1:0] per_lvl_ok;
   logic [N_LVL-1:0] lvl_hot;

   assign is_ns  = (sec_state == SEC_NONSEC);
   assign is_rl  = (sec_state == SEC_REALM);
   assign is_sec = (sec_state == SEC_SECURE) || (sec_state == SEC_RSVD);

   // level 0: primary exclude plus "differs" secondaries
   assign per_lvl_ok[0] = !ctrl.excl_l0
                        && !(is_ns && (ctrl.ns_l0 != ctrl.excl_l0))
                        && !(is_rl && (ctrl.rl_l0 != ctrl.excl_l0));

   // level 1: same shape against the level-1 primary
   assign per_lvl_ok[1] = !ctrl.excl_l1
                        && !(is_ns && (ctrl.ns_l1 != ctrl.excl_l1))
                        && !(is_rl && (ctrl.rl_l1 != ctrl.excl_l1));

   // level 2: inverted primary, "equals" secondaries
   assign per_lvl_ok[2] = ctrl.keep_l2
                        && !(is_sec && (ctrl.sec_l2 == ctrl.keep_l2))
                        && !(is_rl  && (ctrl.rl_l2  == ctrl.keep_l2));

   // level 3: secondary compared against the level-1 primary
   assign per_lvl_ok[3] = (ctrl.l3_sel == ctrl.excl_l1);

   generate
      for (genvar gi = 0; gi < N_LVL; gi++) begin : g_hot
         assign lvl_hot[gi] = (cur_level == LVL_W'(gi));
      end
   endgenerate

   assign lvl_allow = |(lvl_hot & per_lvl_ok);

endmodule

// File: rtl/plp_mode_term.sv
module plp_mode_term
   import plp_pkg::*;
(
   input  logic [VSEL_W-1:0] vec_filter,
   input  logic              vec_streaming,
   input  logic              in_txn,
   input  logic              evt_attrib,
   input  logic              excl_nontxn,
   output logic              mode_allow
);

   logic vec_ok;
   logic txn_ok;

   always_comb begin
      unique case (plp_vsel_e'(vec_filter))
         VSEL_NO_STRM:  vec_ok = !vec_streaming;
         VSEL_NO_NSTRM: vec_ok = vec_streaming;
         default:       vec_ok = 1'b1;
      endcase
   end

   assign txn_ok     = !(excl_nontxn && evt_attrib && !in_txn);
   assign mode_allow = vec_ok && txn_ok;

endmodule

// File: rtl/plp_gate_reg.sv
module plp_gate_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
   end

endmodule

// File: rtl/plp_event_filter.sv
module plp_event_filter
   import plp_pkg::*;
#(
   parameter int unsigned HAS_SEC_L2 = 1,
   parameter int unsigned HAS_REALM  = 1,
   parameter int unsigned HAS_L3     = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cur_level,
   input  logic [1:0] sec_state,
   input  logic       vec_streaming,
   input  logic       in_txn,
   input  logic       evt_attrib,
   input  logic       excl_l1,
   input  logic       excl_l0,
   input  logic       ns_l1_sel,
   input  logic       ns_l0_sel,
   input  logic       keep_l2,
   input  logic       l3_sel,
   input  logic       sec_l2_sel,
   input  logic       rl_l1_sel,
   input  logic       rl_l0_sel,
   input  logic       rl_l2_sel,
   input  logic       excl_nontxn,
   input  logic [1:0] vec_filter,
   output logic       count_allow
);

   generate
      if (HAS_SEC_L2 > 1) begin : g_chk_sec
         $error("HAS_SEC_L2 must be 0 or 1");
      end
      if (HAS_REALM > 1) begin : g_chk_rl
         $error("HAS_REALM must be 0 or 1");
      end
      if (HAS_L3 > 1) begin : g_chk_l3
         $error("HAS_L3 must be 0 or 1");
      end
      if (LVL_W != 2 || SEC_W != 2 || VSEL_W != 2) begin : g_chk_w
         $error("port widths do not match package widths");
      end
   endgenerate

   plp_lvl_ctrl_t raw_ctrl;
   plp_lvl_ctrl_t eff_ctrl;
   logic          lvl_allow;
   logic          mode_allow;
   logic          allow_d;

   always_comb begin
      raw_ctrl.excl_l1 = excl_l1;
      raw_ctrl.excl_l0 = excl_l0;
      raw_ctrl.ns_l1   = ns_l1_sel;
      raw_ctrl.ns_l0   = ns_l0_sel;
      raw_ctrl.keep_l2 = keep_l2;
      raw_ctrl.l3_sel  = l3_sel;
      raw_ctrl.sec_l2  = sec_l2_sel;
      raw_ctrl.rl_l1   = rl_l1_sel;
      raw_ctrl.rl_l0   = rl_l0_sel;
      raw_ctrl.rl_l2   = rl_l2_sel;
   end

   plp_ctrl_mask #(
      .HAS_SEC_L2 (HAS_SEC_L2),
      .HAS_REALM  (HAS_REALM),
      .HAS_L3     (HAS_L3)
   ) u_mask (
      .raw_ctrl (raw_ctrl),
      .eff_ctrl (eff_ctrl)
   );

   plp_level_term u_lvl (
      .cur_level (cur_level),
      .sec_state (sec_state),
      .ctrl      (eff_ctrl),
      .lvl_allow (lvl_allow)
   );

   plp_mode_term u_mode (
      .vec_filter    (vec_filter),
      .vec_streaming (vec_streaming),
      .in_txn        (in_txn),
      .evt_attrib    (evt_attrib),
      .excl_nontxn   (excl_nontxn),
      .mode_allow    (mode_allow)
   );

   assign allow_d = lvl_allow && mode_allow;

   plp_gate_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (allow_d),
      .q     (count_allow)
   );

endmodule

// File: rtl/plp_event_filter_chk.sv
module plp_event_filter_chk #(
   parameter int unsigned HAS_SEC_L2 = 1,
   parameter int unsigned HAS_REALM  = 1,
   parameter int unsigned HAS_L3     = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cur_level,
   input logic [1:0] sec_state,
   input logic       vec_streaming,
   input logic       in_txn,
   input logic       evt_attrib,
   input logic       excl_l1,
   input logic       excl_l0,
   input logic       ns_l0_sel,
   input logic       keep_l2,
   input logic       l3_sel,
   input logic       sec_l2_sel,
   input logic       excl_nontxn,
   input logic [1:0] vec_filter,
   input logic       count_allow
);

   logic l3_eff;
   logic sec_l2_eff;
   assign l3_eff     = (HAS_L3 != 0) ? l3_sel : 1'b0;
   assign sec_l2_eff = (HAS_SEC_L2 != 0) ? sec_l2_sel : 1'b0;

   // R1: reset holds the gate closed
   a_r1_reset_low: assert property (@(posedge clk)
      !rst_n |=> !count_allow);

   // R2: fully permissive non-secure level 0 opens the gate next cycle
   a_r2_open_path: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == 2'd0 && sec_state == 2'b01 && !excl_l0 && !ns_l0_sel
       && vec_filter == 2'b00 && !excl_nontxn) |=> count_allow);

   // R3
   a_r3_l1_primary: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == 2'd1 && excl_l1) |=> !count_allow);

   // R4
   a_r4_l0_primary: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == 2'd0 && excl_l0) |=> !count_allow);

   // R7
   a_r7_l2_primary: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == 2'd2 && !keep_l2) |=> !count_allow);

   a_r7_l2_secure: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == 2'd2 && sec_state == 2'b00 && sec_l2_eff == keep_l2)
      |=> !count_allow);

   // R8
   a_r8_l3_differs: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_level == 2'd3 && l3_eff != excl_l1) |=> !count_allow);

   // R9
   a_r9_vec_block: assert property (@(posedge clk) disable iff (!rst_n)
      ((vec_filter == 2'b01 && vec_streaming) ||
       (vec_filter == 2'b10 && !vec_streaming)) |=> !count_allow);

   // R10
   a_r10_nontxn: assert property (@(posedge clk) disable iff (!rst_n)
      (excl_nontxn && evt_attrib && !in_txn) |=> !count_allow);

endmodule

bind plp_event_filter plp_event_filter_chk #(
   .HAS_SEC_L2 (HAS_SEC_L2),
   .HAS_REALM  (HAS_REALM),
   .HAS_L3     (HAS_L3)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cur_level     (cur_level),
   .sec_state     (sec_state),
   .vec_streaming (vec_streaming),
   .in_txn        (in_txn),
   .evt_attrib    (evt_attrib),
   .excl_l1       (excl_l1),
   .excl_l0       (excl_l0),
   .ns_l0_sel     (ns_l0_sel),
   .keep_l2       (keep_l2),
   .l3_sel        (l3_sel),
   .sec_l2_sel    (sec_l2_sel),
   .excl_nontxn   (excl_nontxn),
   .vec_filter    (vec_filter),
   .count_allow   (count_allow)
);

// File: tb/plp_event_filter_tb.sv
module plp_event_filter_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] cur_level, sec_state, vec_filter;
   logic       vec_streaming, in_txn, evt_attrib;
   logic       excl_l1, excl_l0, ns_l1_sel, ns_l0_sel, keep_l2, l3_sel;
   logic       sec_l2_sel, rl_l1_sel, rl_l0_sel, rl_l2_sel, excl_nontxn;
   logic       count_allow;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #10 clk = ~clk;   // 50 MHz

   plp_event_filter u_dut (.*);

   // Behavioural reference: returns the decision and the requirement
   // responsible for it.
   function automatic bit ref_allow(output string tag);
      bit secure_like;
      secure_like = (sec_state == 2'b00) || (sec_state == 2'b11);
      tag = "R2";
      case (cur_level)
         2'd0: begin
            if (excl_l0) begin tag = "R4"; return 0; end
            if (sec_state == 2'b01 && ns_l0_sel !== excl_l0) begin tag = "R5"; return 0; end
            if (sec_state == 2'b10 && rl_l0_sel !== excl_l0) begin tag = "R6"; return 0; end
         end
         2'd1: begin
            if (excl_l1) begin tag = "R3"; return 0; end
            if (sec_state == 2'b01 && ns_l1_sel !== excl_l1) begin tag = "R5"; return 0; end
            if (sec_state == 2'b10 && rl_l1_sel !== excl_l1) begin tag = "R6"; return 0; end
         end
         2'd2: begin
            if (!keep_l2) begin tag = "R7"; return 0; end
            if (secure_like && sec_l2_sel == keep_l2) begin tag = "R7"; return 0; end
            if (sec_state == 2'b10 && rl_l2_sel == keep_l2) begin tag = "R7"; return 0; end
         end
         default: begin
            if (l3_sel != excl_l1) begin tag = "R8"; return 0; end
         end
      endcase
      if (vec_filter == 2'b01 && vec_streaming)  begin tag = "R9"; return 0; end
      if (vec_filter == 2'b10 && !vec_streaming) begin tag = "R9"; return 0; end
      if (excl_nontxn && evt_attrib && !in_txn)  begin tag = "R10"; return 0; end
      return 1;
   endfunction

   // inputs already set; one posedge captures them; compare at next negedge
   task automatic step(input string note);
      bit    exp;
      string tag;
      exp = rst_n ? ref_allow(tag) : 1'b0;
      if (!rst_n) tag = "R1";
      @(negedge clk);
      n_checks++;
      if (count_allow !== exp) begin
         n_fail++;
         $display("FAIL %s (%s): count_allow=%0b expected=%0b lvl=%0d sec=%0d",
                  tag, note, count_allow, exp, cur_level, sec_state);
      end
   endtask

   task automatic permissive();
      cur_level = 2'd0; sec_state = 2'b01;
      vec_streaming = 0; in_txn = 0; evt_attrib = 1;
      excl_l1 = 0; excl_l0 = 0; ns_l1_sel = 0; ns_l0_sel = 0;
      keep_l2 = 1; l3_sel = 0; sec_l2_sel = 0;
      rl_l1_sel = 0; rl_l0_sel = 0; rl_l2_sel = 0;
      excl_nontxn = 0; vec_filter = 2'b00;
   endtask

   task automatic randomize_inputs();
      logic [31:0] r;
      r = $urandom;
      cur_level = r[1:0]; sec_state = r[3:2]; vec_filter = r[5:4];
      vec_streaming = r[6]; in_txn = r[7]; evt_attrib = r[8];
      excl_l1 = r[9]; excl_l0 = r[10]; ns_l1_sel = r[11]; ns_l0_sel = r[12];
      keep_l2 = r[13]; l3_sel = r[14]; sec_l2_sel = r[15];
      rl_l1_sel = r[16]; rl_l0_sel = r[17]; rl_l2_sel = r[18];
      excl_nontxn = r[19] & r[20];
      if (r[21]) vec_filter = 2'b00;
   endtask

   initial begin
      rst_n = 0;
      permissive();
      // R1: closed in reset even with permissive inputs
      for (int i = 0; i < 3; i++) step("reset R1");
      rst_n = 1;
      step("first open R2");
      step("steady open R2");

      // R3/R4 primaries in each state; R11 other-level bits ignored
      for (int s = 0; s < 4; s++) begin
         permissive(); sec_state = 2'(s);
         cur_level = 2'd1; excl_l1 = 1; ns_l1_sel = 1; rl_l1_sel = 1; step("R3 primary");
         excl_l1 = 0; ns_l1_sel = 0; rl_l1_sel = 0; excl_l0 = 1; step("R11 l0 bit at l1");
         cur_level = 2'd0; ns_l0_sel = 1; rl_l0_sel = 1; step("R4 primary");
      end

      // R5/R6 secondaries crossed with primaries, R11 in foreign states
      for (int s = 0; s < 4; s++) begin
         for (int lv = 0; lv < 2; lv++) begin
            for (int v = 0; v < 4; v++) begin
               permissive(); sec_state = 2'(s); cur_level = 2'(lv);
               if (lv == 0) begin ns_l0_sel = v[0]; rl_l0_sel = v[1]; end
               else begin ns_l1_sel = v[0]; rl_l1_sel = v[1]; end
               step("R5 R6 R11 secondary");
            end
         end
      end

      // R7 level-2 matrix
      for (int s = 0; s < 4; s++) begin
         for (int v = 0; v < 8; v++) begin
            permissive(); sec_state = 2'(s); cur_level = 2'd2;
            keep_l2 = v[0]; sec_l2_sel = v[1]; rl_l2_sel = v[2];
            excl_l1 = 1; excl_l0 = 1;
            step("R7 level2");
         end
      end

      // R8 level 3
      for (int v = 0; v < 8; v++) begin
         permissive(); cur_level = 2'd3;
         l3_sel = v[0]; excl_l1 = v[1]; excl_l0 = v[2];
         step("R8 level3");
      end

      // R9 vector selector, all codes both modes
      for (int v = 0; v < 8; v++) begin
         permissive(); vec_filter = v[1:0]; vec_streaming = v[2];
         step("R9 vector");
      end

      // R10 transactional filter
      for (int v = 0; v < 8; v++) begin
         permissive(); excl_nontxn = v[0]; evt_attrib = v[1]; in_txn = v[2];
         step("R10 txn");
      end

      // mid-run reset, R1
      rst_n = 0; permissive(); step("mid reset R1");
      rst_n = 1; step("after reset R2");

      // random sweep, compared every cycle (R2 registration)
      for (int i = 0; i < 4000; i++) begin
         randomize_inputs();
         step("random");
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule